// File: doc/BRIEF.md
# Trace Capture Buffer Controller

This block keeps a short on-chip history of program activity for a debug host. It holds eight 16-bit entries. In normal mode each entry is a change-of-flow target address. In event mode each entry is a data value that was read or written at a watched location. A trigger pulse comes from a separate trigger unit and decides when recording stops or starts.

The capture mode is fixed when the host arms the block:

- **Pre-trigger (end) mode.** The store runs as a ring and always holds the most recent entries. The trigger freezes it.
- **Post-trigger (begin) mode.** Nothing is recorded until the trigger. Recording then runs until the store is full.
- **Event mode.** It always behaves as post-trigger capture, whatever the end/begin setting says.

When the capture sequence completes, the block raises a completion flag. If halting is enabled, it also raises a halt request toward the CPU.

The host reads entries oldest first. The oldest entry is presented on the read data port, and each read strobe removes it. Reads are accepted at any time, so a host that stops the CPU early can still read a partial capture.

Top module: `trc_capture_ctrl`

## Requirements
- R1: After reset, and on the cycle after an `arm` pulse, `count` is 0, `done` is 0 and `halt_req` is 0. Any strobe or trigger in the `arm` cycle is ignored.
- R2: The store holds at most 8 entries of 16 bits, and `count` saturates at 8.
  - When `count` is nonzero, `rd_data` shows the oldest entry.
  - A `rd_req` removes that entry. A `rd_req` while `count` is 0 has no effect.
- R3: End mode is used when `end_mode`=1 and `event_only`=0 at arm time.
  - Every accepted strobe from arm onward is recorded. Once 8 entries are held, the oldest is overwritten.
  - A `trig` stops recording. A strobe in the trigger cycle is still recorded.
  - `done` rises in the cycle after the trigger.
- R4: Begin mode is used when `end_mode`=0 at arm time.
  - Strobes before the trigger are ignored. Recording starts with the trigger cycle, so a strobe in that cycle is kept.
  - `done` rises in the cycle after the write that brings `count` to 8.
- R5: When `event_only`=1:
  - Only `evt_vld` strobes are recorded, stored as {8'h00, `evt_data`}.
  - `cof_vld` strobes are ignored.
  - Capture behaves as begin mode even if `end_mode`=1.
- R6: When `event_only`=0, only `cof_vld` strobes are recorded, storing `cof_addr`, and `evt_vld` strobes are ignored.
- R7: `halt_req` rises together with `done` when `halt_en` is 1 at completion, and is held until the next arm. When `halt_en` is 0 it stays 0.
- R8: Once `done` is set, strobes and triggers are ignored until the next arm. The store is frozen, and only host reads change it.
- R9: Entries recorded before completion can be read while recording is still open, and they keep their order.
- R10: Before the first arm, `trig` and strobes record nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Pulse: clear the store and start a capture sequence |
| end_mode | input | 1 | 1 = pre-trigger ring, 0 = post-trigger fill (sampled at arm) |
| event_only | input | 1 | 1 = record event data, forces post-trigger capture |
| halt_en | input | 1 | Request a CPU halt at completion |
| trig | input | 1 | Qualified trigger pulse |
| cof_vld | input | 1 | Change-of-flow strobe |
| cof_addr | input | 16 | Change-of-flow target address |
| evt_vld | input | 1 | Event data strobe |
| evt_data | input | 8 | Event data value |
| rd_req | input | 1 | Host read strobe, removes the oldest entry |
| rd_data | output | 16 | Oldest stored entry |
| count | output | 4 | Number of valid entries, 0 to 8 |
| done | output | 1 | Capture sequence complete |
| halt_req | output | 1 | Halt request toward the CPU |

## Verification
The embedded properties watch, on every cycle, the invariants that need no scenario:

- the occupancy limit and the clear on arm;
- a full ring staying full while it overwrites;
- reads draining one entry;
- `halt_req` implying `done` and holding;
- a frozen count after completion;
- a pre-trigger stop producing completion one cycle later.

Only the bench scenarios can show which entries survive and in what order: the ring keeping the last eight before the trigger, strobes ignored before a post-trigger start, event mode overriding the end setting, and partial reads during recording. The bench compares every cycle against its own queue model.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_WAIT = 3'd2,
    ST_POST = 3'd3,
    ST_DONE = 3'd4
  } trc_state_t;
endpackage

// File: rtl/trc_src_mux.sv
module trc_src_mux #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          event_only,
  input  logic          cof_vld,
  input  logic [AW-1:0] cof_addr,
  input  logic          evt_vld,
  input  logic [DW-1:0] evt_data,
  output logic          ent_vld,
  output logic [AW-1:0] ent_val
);
  logic [AW-1:0] evt_wide;

  generate
    if (DW == AW) begin : g_same
      assign evt_wide = evt_data;
    end else begin : g_pad
      assign evt_wide = {{(AW-DW){1'b0}}, evt_data};
    end
  endgenerate

  always_comb begin
    if (event_only) begin
      ent_vld = evt_vld;
      ent_val = evt_wide;
    end else begin
      ent_vld = cof_vld;
      ent_val = cof_addr;
    end
  end

  // R5 / R6: the source flag must gate which strobe reaches the store.
  always_comb begin
    if (event_only && !evt_vld) a_r5_evt_gate: assert (!ent_vld);
    if (!event_only && !cof_vld) a_r6_cof_gate: assert (!ent_vld);
  end
endmodule

// File: rtl/trc_store.sv
module trc_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_val,
  input  logic          rd_en,
  output logic [AW-1:0] rd_val,
  output logic [CW-1:0] count,
  output logic          fill_hit
);
  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          rd_take, wr_take, ovr;

  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] occ_step(input logic [CW-1:0] c,
                                             input logic w, input logic r);
    if (w && r) return c;
    if (w) return (c == CW'(DEPTH)) ? c : c + 1'b1;
    if (r) return c - 1'b1;
    return c;
  endfunction

  assign wr_take  = wr_en && !clr;
  assign rd_take  = rd_en && !clr && (cnt != '0);
  assign ovr      = wr_take && !rd_take && (cnt == CW'(DEPTH));
  assign cnt_nxt  = occ_step(cnt, wr_take, rd_take);
  assign fill_hit = wr_take && (cnt_nxt == CW'(DEPTH));
  assign rd_val   = mem[rptr];
  assign count    = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_take) wptr <= ptr_step(wptr);
      if (rd_take || ovr) rptr <= ptr_step(rptr);
      cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_take) begin
      mem[wptr] <= wr_val;
    end
  end

  a_r2_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  a_r2_ring_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && !rd_en && cnt == CW'(DEPTH)) |=> (cnt == CW'(DEPTH)));
  a_r2_read_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !clr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/trc_seq.sv
module trc_seq
  import trc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic trig,
  input  logic begin_eff,
  input  logic halt_en,
  input  logic fill_hit,
  output logic rec_en,
  output logic done,
  output logic halt_req
);
  trc_state_t st, st_nxt;
  logic trig_stop, trig_start, seq_fill, finish;

  assign trig_stop  = (st == ST_PRE) && trig;
  assign trig_start = (st == ST_WAIT) && trig;
  assign rec_en     = !arm && ((st == ST_PRE) || (st == ST_POST) || trig_start);
  assign seq_fill   = ((st == ST_POST) || trig_start) && fill_hit;
  assign finish     = !arm && (trig_stop || seq_fill);

  always_comb begin
    st_nxt = st;
    if (arm)             st_nxt = begin_eff ? ST_WAIT : ST_PRE;
    else if (finish)     st_nxt = ST_DONE;
    else if (trig_start) st_nxt = ST_POST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      halt_req <= 1'b0;
    end else begin
      st <= st_nxt;
      if (arm)         halt_req <= 1'b0;
      else if (finish) halt_req <= halt_en;
    end
  end

  assign done = (st == ST_DONE);

  a_r7_halt_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> done);
  a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !arm) |=> halt_req);
  a_r8_done_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);
  a_r3_stop_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_stop && !arm) |=> done);
  a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !rec_en);
  a_r1_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!done && !halt_req));
endmodule

// File: rtl/trc_capture_ctrl.sv
module trc_capture_ctrl #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          end_mode,
  input  logic          event_only,
  input  logic          halt_en,
  input  logic          trig,
  input  logic          cof_vld,
  input  logic [AW-1:0] cof_addr,
  input  logic          evt_vld,
  input  logic [DW-1:0] evt_data,
  input  logic          rd_req,
  output logic [AW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          done,
  output logic          halt_req
);
  logic          ent_vld;
  logic [AW-1:0] ent_val;
  logic          rec_en, wr_fire, fill_hit, begin_eff;

  assign begin_eff = event_only || !end_mode;
  assign wr_fire   = rec_en && ent_vld;

  trc_src_mux #(.AW(AW), .DW(DW)) u_mux (
    .event_only(event_only), .cof_vld(cof_vld), .cof_addr(cof_addr),
    .evt_vld(evt_vld), .evt_data(evt_data),
    .ent_vld(ent_vld), .ent_val(ent_val)
  );

  trc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig),
    .begin_eff(begin_eff), .halt_en(halt_en), .fill_hit(fill_hit),
    .rec_en(rec_en), .done(done), .halt_req(halt_req)
  );

  trc_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(arm), .wr_en(wr_fire), .wr_val(ent_val),
    .rd_en(rd_req), .rd_val(rd_data), .count(count), .fill_hit(fill_hit)
  );

  // R8: after completion only host reads may change occupancy.
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm && !rd_req) |=> $stable(count));
endmodule

// File: tb/test_trc_capture_ctrl.sv
module test_trc_capture_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, end_mode = 0, event_only = 0, halt_en = 0, trig = 0;
  logic cof_vld = 0, evt_vld = 0, rd_req = 0;
  logic [15:0] cof_addr = '0;
  logic [7:0]  evt_data = '0;
  logic [15:0] rd_data;
  logic [3:0]  count;
  logic        done, halt_req;

  int n_tests = 0, n_fail = 0;
  int q[$];
  int mst = 0;       // 0 idle,1 pre,2 wait,3 post,4 done
  bit mhalt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trc_capture_ctrl i_trc_capture_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .end_mode(end_mode),
    .event_only(event_only), .halt_en(halt_en), .trig(trig),
    .cof_vld(cof_vld), .cof_addr(cof_addr), .evt_vld(evt_vld),
    .evt_data(evt_data), .rd_req(rd_req), .rd_data(rd_data),
    .count(count), .done(done), .halt_req(halt_req)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void model_step();
    bit rec, wr;
    int val;
    if (arm) begin
      q.delete();
      mhalt = 0;
      mst = (end_mode && !event_only) ? 1 : 2;
      return;
    end
    rec = (mst == 1) || (mst == 3) || (mst == 2 && trig);
    wr  = rec && (event_only ? evt_vld : cof_vld);
    val = event_only ? int'(evt_data) : int'(cof_addr);
    if (rd_req && q.size() > 0) void'(q.pop_front());
    if (wr) q.push_back(val);
    if (q.size() > 8) void'(q.pop_front());
    if (mst == 1 && trig) begin
      mst = 4; mhalt = halt_en;
    end else if (mst == 2 && trig) begin
      mst = 3;
      if (wr && q.size() == 8) begin mst = 4; mhalt = halt_en; end
    end else if (mst == 3 && wr && q.size() == 8) begin
      mst = 4; mhalt = halt_en;
    end
  endfunction

  task automatic compare(string tag);
    chk(tag, "count", int'(count), q.size());
    chk(tag, "done", int'(done), int'(mst == 4));
    chk(tag, "halt_req", int'(halt_req), int'(mhalt));
    if (q.size() > 0) chk(tag, "rd_data", int'(rd_data), q[0]);
  endtask

  task automatic cyc(bit a, bit t, bit cv, int ca, bit ev, int ed, bit rd,
                     string tag);
    @(negedge clk);
    arm = a; trig = t; cof_vld = cv; cof_addr = 16'(ca);
    evt_vld = ev; evt_data = 8'(ed); rd_req = rd;
    model_step();
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic set_mode(bit em, bit eo, bit he);
    @(negedge clk);
    end_mode = em; event_only = eo; halt_en = he;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    rst_n = 1'b1;

    // R10: activity before any arm
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 16'hAA00 + i, 1, i, 0, "R10");

    // R3 / R6 / R7: end mode wraps, trigger keeps the last eight
    set_mode(1, 0, 1);
    cyc(1, 0, 1, 16'hDEAD, 0, 0, 0, "R1 arm");
    for (int i = 0; i < 11; i++)
      cyc(0, 0, 1, 16'h1000 + i, (i % 3) == 0, 8'h55, 0, "R3 R6");
    cyc(0, 1, 1, 16'h100B, 0, 0, 0, "R3 R7 trigger");
    // R8: frozen after completion
    for (int i = 0; i < 4; i++) cyc(0, i == 2, 1, 16'h2000 + i, 0, 0, 0, "R8");
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, 0, 0, 0, 1, "R2 R3 readout");
    cyc(0, 0, 0, 0, 0, 0, 1, "R2 empty read");

    // R4 / R7: begin mode, no halt
    set_mode(0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, "R1 arm");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 16'h3000 + i, 0, 0, 0, "R4 pre");
    cyc(0, 1, 1, 16'h3100, 0, 0, 0, "R4 start");
    for (int i = 1; i < 8; i++) cyc(0, 0, 1, 16'h3100 + i, 0, 0, 0, "R4 R7 fill");
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 16'h3F00, 0, 0, 0, "R8");
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 0, 1, "R4 readout");

    // R5: event mode overrides end setting, zero-extends
    set_mode(1, 1, 1);
    cyc(1, 0, 0, 0, 0, 0, 0, "R1 arm");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 16'h4000, 1, 8'hE0 + i, 0, "R5 pre");
    for (int i = 0; i < 8; i++)
      cyc(0, i == 0, 1, 16'h4100, 1, 8'hF0 + i, 0, "R5 R7");
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 0, 1, "R5 readout");

    // R9: partial capture readable before completion
    set_mode(1, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, "R1 arm");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 16'h5000 + i, 0, 0, 0, "R9 rec");
    cyc(0, 0, 0, 0, 0, 0, 1, "R9 read");
    cyc(0, 0, 1, 16'h5003, 0, 0, 1, "R9 read+write");
    cyc(0, 0, 0, 0, 0, 0, 1, "R9 read");

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      bit a = ($urandom % 48) == 0;
      if (a) set_mode(1'($urandom), 1'(($urandom % 3) == 0), 1'($urandom));
      cyc(a, ($urandom % 20) == 0, 1'($urandom), $urandom, 1'($urandom),
          $urandom, ($urandom % 4) == 0, "R2 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule